// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block is a small timekeeping peripheral that sits on a narrow read/write bus. It exposes sixteen 4-bit registers through a 4-bit address. From a 10 Hz enable pulse it counts tenths of a second, seconds, minutes, hours, day of month, month, a two-digit year and a day of the week, every field held as BCD digits. Leap years are handled by a stored 2-bit counter that advances with the year.

Software reads a multi-digit time one nibble at a time. A read-to-clear "time changed" flag in the control register shows whether a tick landed during that read, so the read can be retried. A periodic interrupt is generated from a selectable interval between 0.1 s and 60 s. The highest address holds two registers: the clock-setting register (12/24-hour mode and leap counter) and the interrupt-period register. A control bit picks which one is visible.

Top module: `bcd_rtc`

## Requirements
- R1: After reset every register reads 0, with four exceptions: day units, month units and weekday each read 1, and address 15 reads 1 (the setting register in 24-hour mode). The map is: 0 control, 1 tenths, 2/3 seconds units/tens, 4/5 minutes, 6/7 hours, 8/9 day, 10/11 month, 12/13 year (units/tens), 14 weekday, 15 setting or interrupt register.
- R2: Each tick advances tenths from 0 to 9. The tick after 9 returns tenths to 0 and advances the seconds.
- R3: In 24-hour mode the time carries in BCD through 59 s, 59 min and 23 h to 00:00:00. That carry advances the day, and the weekday counts 1 to 7 and wraps to 1.
- R4: When setting bit 0 is 0 (12-hour mode), hours run 12, 1, ..., 11. Hours-tens bit 3 is the PM flag and toggles on 11→12. Passing 11 PM to 12 AM advances the day.
- R5: The day of month wraps to 01 after 30 in months 4, 6, 9 and 11, and after 31 in the other months. In February it wraps after 29 when the leap counter (setting bits 3:2) is 00, and after 28 otherwise.
- R6: Rolling past December 31 gives January 1 and advances the year. Year 99 wraps to 00, and the leap counter advances modulo 4 on each year increment.
- R7: A control read returns the time-changed flag on bit 3. Each tick that advances time sets the flag, and a read of address 0 clears it. A tick in the same cycle as the read wins.
- R8: Control bit 2 = 1 stops the clock and holds tenths at 0. Writes to addresses 2 to 14 load digits only while stopped and are ignored while running. Writes to address 1 are always ignored.
- R9: Control bit 1 selects the register at address 15: 1 selects the interrupt-period register, 0 selects the setting register. Reads and writes follow the same selection.
- R10: Interrupt-period bits 2:0 choose the period in ticks: 0 off, then 1, 5, 10, 50, 100, 300 and 600 for codes 1 to 7. Writing the register restarts the period count.
- R11: When a period elapses, the interrupt flag (control read bit 0) is set, and a control read clears it. `irq` is the flag gated by control bit 0 = 0; control bit 0 = 1 stops the output but not the flag.
- R12: Control bit 3 = 1 (test mode) makes every tick advance the seconds directly, with tenths held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 10 Hz time-base enable, one cycle wide |
| cs | input | 1 | Bus access this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for the addressed register, combinational |
| irq | output | 1 | Periodic interrupt, active high |

## Verification
The checks assume that `tick` is a single-cycle pulse and that every bus access lasts exactly one cycle. They also assume that digits loaded while stopped are valid BCD for their field, because the carry logic is only defined for legal values. The bench drives each access and each tick as its own one-cycle operation and never overlaps them. It loads only legal dates and times, so the wrap and leap-year properties stay within those assumptions.

// File: rtl/bcd_rtc.sv
module bcd_rtc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cs,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       irq
);
  logic [3:0] ctl, tenths, sec_u, sec_t, min_u, min_t, hr_u, hr_t;
  logic [3:0] day_u, day_t, mon_u, mon_t, yr_u, yr_t, wday, setreg, intreg;
  logic       dchg, iflag;
  logic [9:0] icnt, period;
  logic [4:0] mon_b;
  logic [5:0] day_b, dim;

  wire wr   = cs & we;
  wire rd0  = cs & ~we & (addr == 4'd0);
  wire adv  = tick & ~ctl[2];
  wire c_ten = adv & (ctl[3] | (tenths == 4'd9));
  wire c_sec = c_ten & (sec_t == 4'd5) & (sec_u == 4'd9);
  wire c_min = c_sec & (min_t == 4'd5) & (min_u == 4'd9);
  wire h24_end = (hr_t == 4'd2) & (hr_u == 4'd3);
  wire h12_end = hr_t[3] & hr_t[0] & (hr_u == 4'd1);
  wire c_hr  = c_min & (setreg[0] ? h24_end : h12_end);
  wire last_day = (day_b == dim);
  wire c_day = c_hr & last_day;
  wire c_mon = c_day & (mon_b == 5'd12);

  assign mon_b = (mon_t[0] ? 5'd10 : 5'd0) + 5'(mon_u);
  assign day_b = 6'(day_t[1:0]) * 6'd10 + 6'(day_u);
  assign irq   = iflag & ~ctl[0];

  always_comb begin
    case (mon_b)
      5'd2:                       dim = (setreg[3:2] == 2'd0) ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:    dim = 6'd30;
      default:                    dim = 6'd31;
    endcase
    case (intreg[2:0])
      3'd1: period = 10'd1;
      3'd2: period = 10'd5;
      3'd3: period = 10'd10;
      3'd4: period = 10'd50;
      3'd5: period = 10'd100;
      3'd6: period = 10'd300;
      3'd7: period = 10'd600;
      default: period = 10'd0;
    endcase
    case (addr)
      4'd0:  rdata = {dchg, 2'b00, iflag};
      4'd1:  rdata = tenths;
      4'd2:  rdata = sec_u;
      4'd3:  rdata = sec_t;
      4'd4:  rdata = min_u;
      4'd5:  rdata = min_t;
      4'd6:  rdata = hr_u;
      4'd7:  rdata = hr_t;
      4'd8:  rdata = day_u;
      4'd9:  rdata = day_t;
      4'd10: rdata = mon_u;
      4'd11: rdata = mon_t;
      4'd12: rdata = yr_u;
      4'd13: rdata = yr_t;
      4'd14: rdata = wday;
      default: rdata = ctl[1] ? intreg : setreg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; tenths <= '0; sec_u <= '0; sec_t <= '0; min_u <= '0; min_t <= '0;
      hr_u <= '0; hr_t <= '0; day_u <= 4'd1; day_t <= '0; mon_u <= 4'd1; mon_t <= '0;
      yr_u <= '0; yr_t <= '0; wday <= 4'd1; setreg <= 4'd1; intreg <= '0;
      dchg <= 1'b0; iflag <= 1'b0; icnt <= '0;
    end else begin
      if (adv) tenths <= (ctl[3] || tenths == 4'd9) ? 4'd0 : tenths + 4'd1;
      else if (ctl[2]) tenths <= 4'd0;

      if (c_ten) begin
        if (sec_u == 4'd9) begin sec_u <= 4'd0; sec_t <= (sec_t == 4'd5) ? 4'd0 : sec_t + 4'd1; end
        else sec_u <= sec_u + 4'd1;
      end
      if (c_sec) begin
        if (min_u == 4'd9) begin min_u <= 4'd0; min_t <= (min_t == 4'd5) ? 4'd0 : min_t + 4'd1; end
        else min_u <= min_u + 4'd1;
      end
      if (c_min) begin
        if (setreg[0]) begin
          if (h24_end) begin hr_u <= 4'd0; hr_t <= 4'd0; end
          else if (hr_u == 4'd9) begin hr_u <= 4'd0; hr_t <= hr_t + 4'd1; end
          else hr_u <= hr_u + 4'd1;
        end else begin
          if (hr_t[0] && hr_u == 4'd2) begin hr_u <= 4'd1; hr_t <= {hr_t[3], 3'd0}; end
          else if (hr_t[0] && hr_u == 4'd1) begin hr_u <= 4'd2; hr_t <= {~hr_t[3], 3'd1}; end
          else if (hr_u == 4'd9) begin hr_u <= 4'd0; hr_t <= {hr_t[3], 3'd1}; end
          else hr_u <= hr_u + 4'd1;
        end
      end
      if (c_hr) begin
        wday <= (wday == 4'd7) ? 4'd1 : wday + 4'd1;
        if (last_day) begin day_u <= 4'd1; day_t <= 4'd0; end
        else if (day_u == 4'd9) begin day_u <= 4'd0; day_t <= day_t + 4'd1; end
        else day_u <= day_u + 4'd1;
      end
      if (c_day) begin
        if (mon_b == 5'd12) begin mon_u <= 4'd1; mon_t <= 4'd0; end
        else if (mon_u == 4'd9) begin mon_u <= 4'd0; mon_t <= 4'd1; end
        else mon_u <= mon_u + 4'd1;
      end
      if (c_mon) begin
        setreg[3:2] <= setreg[3:2] + 2'd1;
        if (yr_u == 4'd9) begin yr_u <= 4'd0; yr_t <= (yr_t == 4'd9) ? 4'd0 : yr_t + 4'd1; end
        else yr_u <= yr_u + 4'd1;
      end

      if (rd0) begin dchg <= 1'b0; iflag <= 1'b0; end
      if (adv) dchg <= 1'b1;

      if (wr && addr == 4'hF && ctl[1]) icnt <= '0;
      else if (tick && period != 10'd0) begin
        if (icnt == period - 10'd1) begin icnt <= '0; iflag <= 1'b1; end
        else icnt <= icnt + 10'd1;
      end

      if (wr) begin
        case (addr)
          4'd0:  ctl <= wdata;
          4'd15: if (ctl[1]) intreg <= wdata; else setreg <= wdata;
          default: if (ctl[2]) begin
            case (addr)
              4'd2:  sec_u <= wdata;
              4'd3:  sec_t <= wdata;
              4'd4:  min_u <= wdata;
              4'd5:  min_t <= wdata;
              4'd6:  hr_u  <= wdata;
              4'd7:  hr_t  <= wdata;
              4'd8:  day_u <= wdata;
              4'd9:  day_t <= wdata;
              4'd10: mon_u <= wdata;
              4'd11: mon_t <= wdata;
              4'd12: yr_u  <= wdata;
              4'd13: yr_t  <= wdata;
              4'd14: wday  <= wdata;
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

module bcd_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cs,
  input logic       we,
  input logic [3:0] addr,
  input logic       irq,
  input logic       stop,
  input logic [3:0] tenths,
  input logic [3:0] sec_u,
  input logic [3:0] yr_u,
  input logic       dchg,
  input logic [1:0] leap
);
  a_r2_tenths_bcd: assert property (@(posedge clk) disable iff (!rst_n) tenths <= 4'd9);
  a_r7_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n) (tick && !stop) |=> dchg);
  a_r11_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 4'd0 && !tick) |=> !irq);
  a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !(cs && we)) |=> ($stable(sec_u) && tenths == 4'd0));
  a_r6_leap_with_year: assert property (@(posedge clk) disable iff (!rst_n)
    (leap != $past(leap)) |-> ($past(cs && we && addr == 4'hF) || (yr_u != $past(yr_u))));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .addr(addr), .irq(irq),
  .stop(ctl[2]), .tenths(tenths), .sec_u(sec_u), .yr_u(yr_u), .dchg(dchg), .leap(setreg[3:2])
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
  logic clk = 0, rst_n = 0, tick = 0, cs = 0, we = 0, irq;
  logic [3:0] addr = 0, wdata = 0, rdata, v;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bcd_rtc u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
              .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    #2 d = rdata;
    @(posedge clk); #1 cs = 0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [3:0] exp);
    logic [3:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic set_time(input logic [3:0] ht, hu, mt, mu, st, su, dt, du, mot, mou, yt, yu, wd, sv);
    wr(0, 4'b0100);
    wr(7, ht); wr(6, hu); wr(5, mt); wr(4, mu); wr(3, st); wr(2, su);
    wr(9, dt); wr(8, du); wr(11, mot); wr(10, mou); wr(13, yt); wr(12, yu); wr(14, wd);
    wr(15, sv);
    wr(0, 4'b0000);
  endtask

  task automatic t_reset;
    rchk("R1 ctl", 0, 0); rchk("R1 tenths", 1, 0); rchk("R1 sec", 2, 0);
    rchk("R1 hr", 7, 0); rchk("R1 day_u", 8, 1); rchk("R1 mon_u", 10, 1);
    rchk("R1 yr", 13, 0); rchk("R1 wday", 14, 1); rchk("R1 setting", 15, 1);
  endtask

  task automatic t_tenths;
    ticks(9);
    rchk("R2 tenths 9", 1, 9); rchk("R2 sec still 0", 2, 0);
    ticks(1);
    rchk("R2 tenths wrap", 1, 0); rchk("R2 sec carry", 2, 1);
    rchk("R7 flag set", 0, 4'b1000); rchk("R7 flag cleared", 0, 0);
  endtask

  task automatic t_roll24;
    set_time(2, 3, 5, 9, 5, 9, 3, 1, 1, 2, 9, 9, 7, 4'b1101);
    ticks(10);
    rchk("R3 sec", 2, 0); rchk("R3 sec_t", 3, 0); rchk("R3 min", 5, 0);
    rchk("R3 hr_u", 6, 0); rchk("R3 hr_t", 7, 0); rchk("R3 wday wrap", 14, 1);
    rchk("R6 day", 8, 1); rchk("R6 day_t", 9, 0); rchk("R6 mon_u", 10, 1); rchk("R6 mon_t", 11, 0);
    rchk("R6 yr_u", 12, 0); rchk("R6 yr_t", 13, 0); rchk("R6 leap wrap", 15, 4'b0001);
  endtask

  task automatic t_months;
    set_time(2, 3, 5, 9, 5, 9, 2, 8, 0, 2, 2, 4, 1, 4'b0001);
    ticks(10);
    rchk("R5 leap feb29", 8, 9); rchk("R5 leap feb", 10, 2);
    set_time(2, 3, 5, 9, 5, 9, 2, 8, 0, 2, 2, 5, 1, 4'b0101);
    ticks(10);
    rchk("R5 feb28 wrap", 8, 1); rchk("R5 to march", 10, 3);
    set_time(2, 3, 5, 9, 5, 9, 3, 0, 0, 4, 2, 5, 1, 4'b0101);
    ticks(10);
    rchk("R5 apr30 wrap", 8, 1); rchk("R5 to may", 10, 5);
    set_time(2, 3, 5, 9, 5, 9, 3, 0, 0, 5, 2, 5, 1, 4'b0101);
    ticks(10);
    rchk("R5 may31", 8, 1); rchk("R5 may31 tens", 9, 3);
  endtask

  task automatic t_12h;
    set_time(1, 1, 5, 9, 5, 9, 0, 5, 0, 6, 2, 5, 3, 4'b0000);
    ticks(10);
    rchk("R4 12pm tens", 7, 9); rchk("R4 12pm units", 6, 2); rchk("R4 no day", 8, 5);
    set_time(9, 2, 5, 9, 5, 9, 0, 5, 0, 6, 2, 5, 3, 4'b0000);
    ticks(10);
    rchk("R4 1pm tens", 7, 8); rchk("R4 1pm units", 6, 1);
    set_time(9, 1, 5, 9, 5, 9, 0, 5, 0, 6, 2, 5, 3, 4'b0000);
    ticks(10);
    rchk("R4 12am tens", 7, 1); rchk("R4 12am units", 6, 2); rchk("R4 day adv", 8, 6);
  endtask

  task automatic t_stop;
    set_time(0, 0, 0, 0, 0, 4, 0, 1, 0, 1, 0, 0, 1, 4'b0001);
    wr(0, 4'b0100);
    ticks(15);
    rchk("R8 tenths held", 1, 0); rchk("R8 sec held", 2, 4);
    wr(1, 5);
    wr(0, 4'b0000);
    rchk("R8 tenths not writable", 1, 0);
    wr(2, 7);
    rchk("R8 write ignored running", 2, 4);
  endtask

  task automatic t_irq;
    wr(0, 4'b0010);
    wr(15, 3);
    rchk("R9 int reg visible", 15, 3);
    rd(0, v);
    ticks(9);
    #5 chk("R10 irq early", {3'b0, irq}, 0);
    ticks(1);
    #5 chk("R11 irq set", {3'b0, irq}, 1);
    rchk("R11 flag bit0", 0, 4'b1001);
    #5 chk("R11 irq cleared", {3'b0, irq}, 0);
    wr(0, 4'b0011);
    ticks(10);
    #5 chk("R11 irq masked", {3'b0, irq}, 0);
    rchk("R11 flag kept", 0, 4'b1001);
    wr(15, 0);
    ticks(20);
    rchk("R10 period off", 0, 4'b1000);
    wr(0, 4'b0000);
    rchk("R9 setting back", 15, 4'b0001);
  endtask

  task automatic t_test;
    set_time(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1, 4'b0001);
    wr(0, 4'b1000);
    ticks(3);
    rchk("R12 fast seconds", 2, 3); rchk("R12 tenths zero", 1, 0);
    wr(0, 4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_tenths; t_roll24; t_months; t_12h; t_stop; t_irq; t_test;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule